// File: doc/BRIEF.md
# SPI Host Controller with Byte Queues

This block is a register-mapped SPI host. Software reaches it through a 32-bit, word-aligned register port. Bytes written to the transmit data word go into a byte queue. While the hold-off bit in the control word is clear, a shift engine takes bytes from that queue in order. It exchanges each one over eight serial clocks and pushes the byte returned by the device into a second byte queue. Software reads that byte back from the receive data word.

The serial side works in clock mode 0: the clock idles low, MOSI changes on the falling edge, MISO is taken on the rising edge, and the most significant bit goes first. The serial clock runs at the system clock divided by an even parameter. The device-select outputs are active low. They follow a select word, and the lowest zero bit in that word names the device. A neighbouring interrupt block receives two one-cycle event strobes: a receive overrun, and the transmit queue draining empty.

Top module: `spi_fifo_host`

## Requirements
- R1: After reset the control word reads 0, the select word reads 1, the status word reads 0x5, and both occupancy words read 0.
- R2: The register words are at these byte addresses: soft reset 0x40, control 0x60, status 0x64, transmit data 0x68, receive data 0x6C, select 0x70, transmit occupancy 0x74, receive occupancy 0x78.
- R3: Writing exactly 0xA to the soft-reset word returns every register and both queues to the R1 state. Writing any other value there changes nothing.
- R4: Writing control bit 5 empties the transmit queue, and writing control bit 6 empties the receive queue. Neither bit is stored, so both always read back 0. The other control bits are stored as written.
- R5: Control bit 8 holds off transfers. While it is 1 no byte leaves the transmit queue and SCLK stays low. While it is 0, queued bytes are sent.
- R6: Status bit 0 is receive empty, bit 1 is receive full, bit 2 is transmit empty and bit 3 is transmit full. All other bits read 0, and writes to the status word are ignored.
- R7: Each queue holds DEPTH bytes (default 256). Full means the occupancy equals DEPTH. A write to a full transmit queue is dropped.
- R8: A read of the receive data word while the receive queue is empty returns 0xDEADBEEF and leaves the queue unchanged. Otherwise the read returns the oldest byte in bits 7:0 and removes it from the queue.
- R9: The selected device is the index of the lowest 0 bit in the select word. If that index is NUM_CS or more, all device selects are high. Otherwise only that device's select is low.
- R10: Bytes are sent in the order they were written, MSB first, in clock mode 0, with SCLK at clk/DIV. Each byte returned by the device is placed in the receive queue.
- R11: An occupancy word reads the queue count minus one, or 0 when the queue is empty.
- R12: A byte that arrives while the receive queue is full is discarded, and ev_rx_overrun pulses for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the receive queue on the data word) |
| reg_addr | input | 7 | Byte address, word aligned |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from the address |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the device |
| spi_miso | input | 1 | Serial data from the device |
| spi_cs_n | output | NUM_CS | Active-low device selects |
| ev_rx_overrun | output | 1 | Pulse: a received byte was discarded |
| ev_tx_empty | output | 1 | Pulse: the last queued transmit byte was taken |

## Verification
The bench goes after these corner cases:
- Filling the transmit queue to exactly DEPTH, and one write past it. A design that mis-sizes the count would wrap, and report empty or lose bytes.
- Receiving one byte beyond a full receive queue. A wrong design would overwrite the oldest data, or stay silent on the overrun strobe.
- Reading an empty receive queue. A careless design would underflow the count or return stale data instead of the marker word.
- A non-key soft-reset write, the self-clearing queue-reset bits, and select words whose lowest zero lies beyond NUM_CS. In each of these, a wrong design would leave state it should not, or drive a device select low.

// File: rtl/spi_fifo_host_pkg.sv
package spi_fifo_host_pkg;

   localparam int ADDR_W = 7;

   typedef enum logic [4:0] {
      W_SOFTRST = 5'h10,
      W_CTRL    = 5'h18,
      W_STAT    = 5'h19,
      W_TXDATA  = 5'h1A,
      W_RXDATA  = 5'h1B,
      W_SELECT  = 5'h1C,
      W_TXOCC   = 5'h1D,
      W_RXOCC   = 5'h1E
   } reg_word_e;

   localparam logic [31:0] SOFT_KEY   = 32'h0000_000A;
   localparam logic [31:0] EMPTY_WORD = 32'hDEAD_BEEF;

   localparam int CTL_TXCLR_BIT = 5;
   localparam int CTL_RXCLR_BIT = 6;
   localparam int CTL_HOLD_BIT  = 8;

   localparam logic [31:0] CTL_CLR_MASK = (32'h1 << CTL_TXCLR_BIT) | (32'h1 << CTL_RXCLR_BIT);

   typedef struct packed {
      logic tx_full;
      logic tx_empty;
      logic rx_full;
      logic rx_empty;
   } stat_t;

endpackage

// File: rtl/sfh_byte_fifo.sv
module sfh_byte_fifo #(
   parameter int DEPTH = 256,
   parameter int W     = 8,
   localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          push,
   input  logic [W-1:0]  din,
   input  logic          pop,
   output logic [W-1:0]  dout,
   output logic [CW-1:0] count,
   output logic          full,
   output logic          empty
);

   logic [W-1:0]  store [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr;
   logic          push_ok, pop_ok;

   assign full    = (count == CW'(DEPTH));
   assign empty   = (count == '0);
   assign push_ok = push && !full;
   assign pop_ok  = pop && !empty;
   assign dout    = store[rd_ptr];

   always_ff @(posedge clk) begin
      if (push_ok && !clr) store[wr_ptr] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else if (clr) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push_ok) wr_ptr <= wr_ptr + 1'b1;
         if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
         case ({push_ok, pop_ok})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

endmodule

// File: rtl/sfh_shift_engine.sv
module sfh_shift_engine #(
   parameter int DIV  = 4,
   localparam int HALF = DIV / 2,
   localparam int HW   = (HALF > 1) ? $clog2(HALF) : 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       abort,
   input  logic       start,
   input  logic [7:0] tx_byte,
   input  logic       miso,
   output logic       sclk,
   output logic       mosi,
   output logic       busy,
   output logic       done,
   output logic [7:0] rx_byte
);

   logic [HW-1:0] phase;
   logic [2:0]    bit_idx;
   logic [7:0]    sh_tx, sh_rx;
   logic          sclk_q;
   logic          edge_due;

   assign edge_due = (phase == HW'(HALF - 1));
   assign sclk     = sclk_q;
   assign mosi     = busy ? sh_tx[7] : 1'b0;
   assign rx_byte  = sh_rx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         done    <= 1'b0;
         phase   <= '0;
         bit_idx <= '0;
         sh_tx   <= '0;
         sh_rx   <= '0;
         sclk_q  <= 1'b0;
      end else if (abort) begin
         busy    <= 1'b0;
         done    <= 1'b0;
         phase   <= '0;
         bit_idx <= '0;
         sclk_q  <= 1'b0;
      end else begin
         done <= 1'b0;
         if (!busy) begin
            if (start) begin
               busy    <= 1'b1;
               sh_tx   <= tx_byte;
               phase   <= '0;
               bit_idx <= '0;
               sclk_q  <= 1'b0;
            end
         end else if (!edge_due) begin
            phase <= phase + 1'b1;
         end else begin
            phase <= '0;
            if (!sclk_q) begin
               sclk_q <= 1'b1;
               sh_rx  <= {sh_rx[6:0], miso};
            end else begin
               sclk_q <= 1'b0;
               if (bit_idx == 3'd7) begin
                  busy <= 1'b0;
                  done <= 1'b1;
               end else begin
                  bit_idx <= bit_idx + 1'b1;
                  sh_tx   <= {sh_tx[6:0], 1'b0};
               end
            end
         end
      end
   end

endmodule

// File: rtl/sfh_cs_decode.sv
module sfh_cs_decode #(
   parameter int NUM_CS = 1
) (
   input  logic [NUM_CS-1:0] sel_word,
   output logic [NUM_CS-1:0] cs_n
);

   for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
      if (i == 0) begin : g_first
         assign cs_n[i] = sel_word[0];
      end else begin : g_rest
         assign cs_n[i] = !(!sel_word[i] && (&sel_word[i-1:0]));
      end
   end

endmodule

// File: rtl/spi_fifo_host.sv
module spi_fifo_host
   import spi_fifo_host_pkg::*;
#(
   parameter int NUM_CS = 1,
   parameter int DEPTH  = 256,
   parameter int DIV    = 4,
   localparam int CW    = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [6:0]        reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              spi_sclk,
   output logic              spi_mosi,
   input  logic              spi_miso,
   output logic [NUM_CS-1:0] spi_cs_n,
   output logic              ev_rx_overrun,
   output logic              ev_tx_empty
);

   initial begin
      assert (DIV >= 2 && DIV % 2 == 0) else $error("DIV must be even and at least 2");
      assert (DEPTH >= 2 && (DEPTH & (DEPTH - 1)) == 0) else $error("DEPTH must be a power of two");
      assert (NUM_CS >= 1 && NUM_CS <= 32) else $error("NUM_CS must be 1..32");
   end

   reg_word_e         word;
   logic [31:0]       ctrl_q;
   logic [NUM_CS-1:0] sel_q;
   logic              soft_rst, ctrl_wr, tx_clr, rx_clr, hold;
   logic              tx_push, rx_pop, eng_start;
   logic [7:0]        tx_dout, rx_dout;
   logic [CW-1:0]     tx_cnt, rx_cnt;
   logic              tx_full, tx_empty, rx_full, rx_empty;
   logic              eng_busy, eng_done;
   logic [7:0]        eng_rx;
   stat_t             stat;

   assign word     = reg_word_e'(reg_addr[6:2]);
   assign soft_rst = reg_wr && (word == W_SOFTRST) && (reg_wdata == SOFT_KEY);
   assign ctrl_wr  = reg_wr && (word == W_CTRL);
   assign tx_clr   = soft_rst || (ctrl_wr && reg_wdata[CTL_TXCLR_BIT]);
   assign rx_clr   = soft_rst || (ctrl_wr && reg_wdata[CTL_RXCLR_BIT]);
   assign hold     = ctrl_q[CTL_HOLD_BIT];
   assign tx_push  = reg_wr && (word == W_TXDATA);
   assign rx_pop   = reg_rd && (word == W_RXDATA);

   // A new byte starts only after the previous done pulse has been consumed.
   assign eng_start = !hold && !tx_empty && !eng_busy && !eng_done && !tx_clr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         sel_q  <= NUM_CS'(1);
      end else if (soft_rst) begin
         ctrl_q <= '0;
         sel_q  <= NUM_CS'(1);
      end else begin
         if (ctrl_wr) ctrl_q <= reg_wdata & ~CTL_CLR_MASK;
         if (reg_wr && word == W_SELECT) sel_q <= reg_wdata[NUM_CS-1:0];
      end
   end

   sfh_byte_fifo #(.DEPTH(DEPTH), .W(8)) u_txq (
      .clk(clk), .rst_n(rst_n), .clr(tx_clr),
      .push(tx_push), .din(reg_wdata[7:0]),
      .pop(eng_start), .dout(tx_dout),
      .count(tx_cnt), .full(tx_full), .empty(tx_empty)
   );

   sfh_byte_fifo #(.DEPTH(DEPTH), .W(8)) u_rxq (
      .clk(clk), .rst_n(rst_n), .clr(rx_clr),
      .push(eng_done), .din(eng_rx),
      .pop(rx_pop), .dout(rx_dout),
      .count(rx_cnt), .full(rx_full), .empty(rx_empty)
   );

   sfh_shift_engine #(.DIV(DIV)) u_eng (
      .clk(clk), .rst_n(rst_n), .abort(soft_rst),
      .start(eng_start), .tx_byte(tx_dout), .miso(spi_miso),
      .sclk(spi_sclk), .mosi(spi_mosi),
      .busy(eng_busy), .done(eng_done), .rx_byte(eng_rx)
   );

   sfh_cs_decode #(.NUM_CS(NUM_CS)) u_cs (
      .sel_word(sel_q), .cs_n(spi_cs_n)
   );

   assign ev_rx_overrun = eng_done && rx_full && !rx_clr;
   assign ev_tx_empty   = eng_start && (tx_cnt == CW'(1)) && !tx_push;

   assign stat = '{tx_full: tx_full, tx_empty: tx_empty, rx_full: rx_full, rx_empty: rx_empty};

   always_comb begin
      reg_rdata = '0;
      case (word)
         W_CTRL:   reg_rdata = ctrl_q;
         W_STAT:   reg_rdata = {28'h0, stat};
         W_RXDATA: reg_rdata = rx_empty ? EMPTY_WORD : {24'h0, rx_dout};
         W_SELECT: reg_rdata = 32'(sel_q);
         W_TXOCC:  reg_rdata = tx_empty ? 32'h0 : 32'(tx_cnt - 1'b1);
         W_RXOCC:  reg_rdata = rx_empty ? 32'h0 : 32'(rx_cnt - 1'b1);
         default:  reg_rdata = '0;
      endcase
   end

endmodule

// File: rtl/spi_fifo_host_chk.sv
module spi_fifo_host_chk #(
   parameter int NUM_CS = 1,
   parameter int DEPTH  = 256,
   parameter int CW     = 9
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic              reg_rd,
   input logic [6:0]        reg_addr,
   input logic [31:0]       reg_wdata,
   input logic [31:0]       reg_rdata,
   input logic              spi_sclk,
   input logic [NUM_CS-1:0] spi_cs_n,
   input logic              ev_rx_overrun,
   input logic [CW-1:0]     tx_cnt,
   input logic [CW-1:0]     rx_cnt,
   input logic              hold,
   input logic              eng_busy
);

   AST_HOLD_BLOCKS_START: assert property (@(posedge clk) disable iff (!rst_n)
      (hold && !eng_busy && !reg_wr) |=> !eng_busy); // R5

   AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !eng_busy |-> !spi_sclk); // R10

   AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~spi_cs_n)); // R9

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_cnt <= CW'(DEPTH)) && (rx_cnt <= CW'(DEPTH))); // R7

   AST_OVERRUN_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      ev_rx_overrun |=> (rx_cnt == CW'(DEPTH)) || (rx_cnt == '0)); // R12

   AST_TXCLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr[6:2] == 5'h18 && reg_wdata[5]) |=> (tx_cnt == '0)); // R4

   AST_EMPTY_READ_MARK: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && reg_addr[6:2] == 5'h1B && rx_cnt == '0) |-> (reg_rdata == 32'hDEAD_BEEF)); // R8

endmodule

bind spi_fifo_host spi_fifo_host_chk #(.NUM_CS(NUM_CS), .DEPTH(DEPTH), .CW(CW)) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
   .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
   .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .ev_rx_overrun(ev_rx_overrun),
   .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .hold(hold), .eng_busy(eng_busy)
);

// File: tb/tb_spi_fifo_host.sv
module tb_spi_fifo_host;

   localparam int NUM_CS = 2;
   localparam int DEPTH  = 256;
   localparam int DIV    = 4;

   localparam logic [6:0] A_SOFT  = 7'h40;
   localparam logic [6:0] A_CTRL  = 7'h60;
   localparam logic [6:0] A_STAT  = 7'h64;
   localparam logic [6:0] A_TXD   = 7'h68;
   localparam logic [6:0] A_RXD   = 7'h6C;
   localparam logic [6:0] A_SEL   = 7'h70;
   localparam logic [6:0] A_TXOCC = 7'h74;
   localparam logic [6:0] A_RXOCC = 7'h78;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic reg_wr = 1'b0, reg_rd = 1'b0;
   logic [6:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic spi_sclk, spi_mosi;
   logic spi_miso = 1'b0;
   logic [NUM_CS-1:0] spi_cs_n;
   logic ev_rx_overrun, ev_tx_empty;

   int checks = 0, failures = 0;
   int ovr_cnt = 0;
   int cs_bad = 0;
   bit run_done = 1'b0;
   logic [31:0] model_sel = 32'h1;

   always #2.5 clk = ~clk;

   spi_fifo_host #(.NUM_CS(NUM_CS), .DEPTH(DEPTH), .DIV(DIV)) dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
      .spi_cs_n(spi_cs_n), .ev_rx_overrun(ev_rx_overrun), .ev_tx_empty(ev_tx_empty)
   );

   // Behavioural device on the serial side: records MOSI, returns resp(k).
   logic [7:0] captured [$];
   int         dev_k = 0;
   int         dev_bit = 0;
   logic [7:0] dev_in = '0;

   function automatic logic [7:0] resp(int k);
      return 8'(8'h3C + k * 7);
   endfunction

   initial spi_miso = resp(0)[7];

   always @(posedge spi_sclk) begin
      dev_in = {dev_in[6:0], spi_mosi};
      dev_bit = dev_bit + 1;
      if (dev_bit == 8) begin
         captured.push_back(dev_in);
         dev_bit = 0;
         dev_k = dev_k + 1;
         spi_miso = resp(dev_k)[7];
      end
   end

   always @(negedge spi_sclk) begin
      if (dev_bit != 0) spi_miso = resp(dev_k)[7 - dev_bit];
   end

   always @(negedge clk) if (rst_n && ev_rx_overrun) ovr_cnt++;

   function automatic logic [NUM_CS-1:0] exp_cs(logic [31:0] s);
      logic [NUM_CS-1:0] r = '1;
      for (int i = 0; i < NUM_CS; i++) begin
         if (!s[i]) begin
            r[i] = 1'b0;
            return r;
         end
      end
      return r;
   endfunction

   // Per-clock comparison of the select outputs with the model (R9)
   always @(posedge clk) begin
      #2;
      if (rst_n && spi_cs_n !== exp_cs(model_sel)) begin
         cs_bad++;
         if (cs_bad < 4)
            $display("FAIL R9 per-clock select got=%b exp=%b", spi_cs_n, exp_cs(model_sel));
      end
   end

   task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s got=0x%08h exp=0x%08h", req, got, exp);
      end
   endtask

   task automatic wr(logic [6:0] a, logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk);
      #1;
      if (a == A_SEL) model_sel = {{(32-NUM_CS){1'b0}}, d[NUM_CS-1:0]};
      if (a == A_SOFT && d == 32'hA) model_sel = 32'h1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(logic [6:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = a;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!run_done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired");
         finish_run();
      end
   end

   initial begin
      logic [31:0] v;
      logic [7:0]  sent [$];
      bit sclk_seen;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R1 reset state, R2 offsets
      rd(A_CTRL, v);  chk("R1 ctrl", v, 32'h0);
      rd(A_SEL, v);   chk("R1 select", v, 32'h1);
      rd(A_STAT, v);  chk("R1 status", v, 32'h5);
      rd(A_TXOCC, v); chk("R1 txocc", v, 32'h0);
      rd(A_RXOCC, v); chk("R1 rxocc", v, 32'h0);
      chk("R9 reset select", 32'(spi_cs_n), 32'(exp_cs(32'h1)));

      // R5 hold-off: queue bytes, no transfer
      wr(A_CTRL, 32'h100);
      wr(A_SEL, 32'hFFFF_FFFE);
      chk("R9 device 0", 32'(spi_cs_n), 32'h2);
      sent = '{8'hC3, 8'h01, 8'h80};
      foreach (sent[i]) wr(A_TXD, 32'(sent[i]));
      rd(A_TXOCC, v); chk("R11 txocc 3 bytes", v, 32'h2);
      rd(A_STAT, v);  chk("R6 status tx pending", v, 32'h1);
      sclk_seen = 1'b0;
      repeat (100) begin
         @(negedge clk);
         if (spi_sclk) sclk_seen = 1'b1;
      end
      chk("R5 no sclk while held", 32'(sclk_seen), 32'h0);
      chk("R5 nothing sent while held", 32'(captured.size()), 32'h0);

      // R5/R10 release and drain
      wr(A_CTRL, 32'h0);
      repeat (200) @(negedge clk);
      chk("R10 three bytes sent", 32'(captured.size()), 32'h3);
      for (int i = 0; i < 3; i++)
         if (i < captured.size()) chk("R10 mosi order", 32'(captured[i]), 32'(sent[i]));
      rd(A_RXOCC, v); chk("R11 rxocc", v, 32'h2);
      for (int i = 0; i < 3; i++) begin
         rd(A_RXD, v); chk("R10 received byte", v, 32'(resp(i)));
      end
      rd(A_STAT, v); chk("R6 status idle", v, 32'h5);

      // R8 empty read
      rd(A_RXD, v);   chk("R8 empty marker", v, 32'hDEAD_BEEF);
      rd(A_RXOCC, v); chk("R8 occupancy unchanged", v, 32'h0);
      rd(A_STAT, v);  chk("R8 still empty", v, 32'h5);

      // R10 write while running starts at once
      wr(A_TXD, 32'h7E);
      repeat (80) @(negedge clk);
      chk("R10 immediate send", 32'(captured.size()), 32'h4);
      if (captured.size() == 4) chk("R10 immediate byte", 32'(captured[3]), 32'h7E);
      rd(A_RXD, v); chk("R10 immediate rx", v, 32'(resp(3)));

      // R6 status write ignored
      wr(A_STAT, 32'hF);
      rd(A_STAT, v); chk("R6 status write ignored", v, 32'h5);

      // R4 transmit queue clear, self-clearing bit
      wr(A_CTRL, 32'h100);
      wr(A_TXD, 32'h11);
      wr(A_TXD, 32'h22);
      wr(A_CTRL, 32'h120);
      rd(A_CTRL, v);  chk("R4 clear bit reads 0", v, 32'h100);
      rd(A_TXOCC, v); chk("R4 tx cleared", v, 32'h0);
      rd(A_STAT, v);  chk("R4 status after clear", v, 32'h5);

      // R7 fill the transmit queue
      for (int i = 0; i < DEPTH; i++) wr(A_TXD, 32'(i));
      rd(A_TXOCC, v); chk("R7 txocc full", v, 32'(DEPTH - 1));
      rd(A_STAT, v);  chk("R7 tx full flag", v, 32'h9);
      wr(A_TXD, 32'hAA);
      rd(A_TXOCC, v); chk("R7 write to full dropped", v, 32'(DEPTH - 1));
      wr(A_CTRL, 32'h0);
      repeat (10000) @(negedge clk);
      chk("R7 all sent", 32'(captured.size()), 32'(4 + DEPTH));
      if (captured.size() == 4 + DEPTH)
         chk("R7 last byte is last kept", 32'(captured[3 + DEPTH]), 32'(DEPTH - 1));
      rd(A_STAT, v);  chk("R6 rx full flag", v, 32'h6);
      rd(A_RXOCC, v); chk("R11 rxocc full", v, 32'(DEPTH - 1));

      // R12 overrun
      chk("R12 no overrun yet", 32'(ovr_cnt), 32'h0);
      wr(A_TXD, 32'h5A);
      repeat (80) @(negedge clk);
      chk("R12 overrun pulse", 32'(ovr_cnt), 32'h1);
      rd(A_RXOCC, v); chk("R12 rx kept old data", v, 32'(DEPTH - 1));
      rd(A_RXD, v);   chk("R12 oldest byte kept", v, 32'(resp(4)));

      // R4 receive queue clear
      wr(A_CTRL, 32'h40);
      rd(A_STAT, v); chk("R4 rx cleared", v, 32'h5);
      rd(A_CTRL, v); chk("R4 rx clear bit reads 0", v, 32'h0);

      // R9 select decode
      wr(A_SEL, 32'hFFFF_FFFD);
      chk("R9 device 1", 32'(spi_cs_n), 32'h1);
      wr(A_SEL, 32'hFFFF_FFFF);
      chk("R9 none selected", 32'(spi_cs_n), 32'h3);
      wr(A_SEL, 32'h0);
      chk("R9 lowest zero wins", 32'(spi_cs_n), 32'h2);

      // R3 soft reset
      wr(A_CTRL, 32'h100);
      wr(A_TXD, 32'h33);
      wr(A_SOFT, 32'h5);
      rd(A_CTRL, v);  chk("R3 bad key ignored ctrl", v, 32'h100);
      rd(A_TXOCC, v); chk("R3 bad key ignored queue", v, 32'h0);
      rd(A_STAT, v);  chk("R3 bad key ignored status", v, 32'h1);
      wr(A_SOFT, 32'hA);
      rd(A_CTRL, v);  chk("R3 ctrl reset", v, 32'h0);
      rd(A_SEL, v);   chk("R3 select reset", v, 32'h1);
      rd(A_STAT, v);  chk("R3 status reset", v, 32'h5);

      checks++;
      if (cs_bad != 0) begin
         failures++;
         $display("FAIL R9 per-clock mismatches got=%0d exp=0", cs_bad);
      end

      run_done = 1'b1;
      finish_run();
   end

endmodule